// File: doc/BRIEF.md
# Event Timer Global Registers

This block holds the shared state of a multi-channel event timer: a 64-bit main counter, a read-only capability word and a small configuration register. The configuration register has a global run bit and a legacy-routing bit. Software reaches these registers through a 32-bit register port that decodes a 1 KB window. Each 64-bit quantity appears as a low dword and a high dword.

The upper part of the window belongs to the comparator channels. The block decodes that part into a channel index and a byte offset and returns the channel's read data through its own response path. It also passes the run state, the legacy state, the counter value and one-cycle arm and halt strobes to the channels.

The counter advances only while the block runs and the tick strobe is high. While the block is stopped the counter holds its value, and only then can software load it one dword at a time.

Top module: `evt_timer_globals`

## Requirements
- R1: After reset the counter, run bit, legacy bit, arm and halt strobes and the read response are all zero.
- R2: Only accesses with `req_size` = 2'b10 (32 bits) take effect. A read of any other size returns zero, and a write of any other size changes nothing.
- R3: The dword at byte offset 0x000 reads as the capability identifier (default 0x8086A201). The dword at 0x004 reads as the tick period in femtoseconds. Writes to both are ignored.
- R4: The configuration dword at 0x010 holds the run flag in bit 0 and the legacy flag in bit 1. A write updates only these two bits, and all other bits read as zero. The dword at 0x014 reads as zero, and writes to it are ignored.
- R5: While the run flag is set, the counter rises by exactly one on each clock with `tick_en` high. It holds its value in every other case where it is not written.
- R6: Reads of 0x0F0 and 0x0F4 return the low and high dwords of the current count. A carry out of the low dword reaches the high dword.
- R7: A write to 0x0F0 or 0x0F4 while the run flag is clear replaces only that dword of the counter. While the run flag is set, such writes are ignored.
- R8: `arm_all` pulses for one cycle in the first cycle that `timer_on` is high after being low. `halt_all` pulses for one cycle in the first cycle that `timer_on` is low after being high.
- R9: `timer_on` follows configuration bit 0, and `legacy_mode` follows configuration bit 1.
- R10: A 32-bit access in byte range 0x100 to 0x3FF with channel index (addr - 0x100) / 0x20 below NUM_CHAN (default 3) raises `chan_sel` in the same cycle. `chan_idx` carries the index, `chan_off` carries addr[4:0], and `chan_we` is raised for a write. The read response of such an access carries `chan_rdata`.
- R11: An access to any other address, including a channel slot at or above NUM_CHAN, reads as zero and changes no state.
- R12: Every read request produces `rsp_valid` high one cycle later, with its data on `rsp_rdata`. Writes and idle cycles produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter tick strobe |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 10 dword |
| req_addr | input | 10 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| timer_on | output | 1 | Global run flag |
| legacy_mode | output | 1 | Legacy routing flag for channel interrupts |
| arm_all | output | 1 | One-cycle strobe: channels re-arm |
| halt_all | output | 1 | One-cycle strobe: channels stop |
| main_count | output | 64 | Current counter value |
| chan_sel | output | 1 | Access targets a channel |
| chan_we | output | 1 | Channel access is a write |
| chan_idx | output | 5 | Channel index |
| chan_off | output | 5 | Byte offset inside the channel slot |
| chan_rdata | input | 32 | Read data from the selected channel |

## Verification
The assertions check the counter on every cycle. A running counter must step by exactly one on each tick and must not move otherwise, and a stopped counter may change only through a write. They also check that each arm or halt strobe matches a real edge of the run flag, that every read gets a response in the next cycle, and that narrow writes leave the flags alone. Other behaviour can only be shown by the bench's scenarios against its own model. This covers the decoded values on reads, the half-word replacement of the counter, the carry from the low dword into the high dword, the refusal of counter loads while running, and the channel index arithmetic with its out-of-range slots.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int WORD_W      = 32;
    localparam int CNT_W       = 64;
    localparam int SIZE_DWORD  = 2;

    localparam int OFF_CAP_LO  = 'h000;
    localparam int OFF_CAP_HI  = 'h004;
    localparam int OFF_CFG_LO  = 'h010;
    localparam int OFF_CFG_HI  = 'h014;
    localparam int OFF_CNT_LO  = 'h0F0;
    localparam int OFF_CNT_HI  = 'h0F4;
    localparam int CHAN_BASE   = 'h100;
    localparam int CHAN_STRIDE = 'h20;

    localparam int CFG_BITS    = 2;
    localparam logic [CFG_BITS-1:0] CFG_WMASK = 2'b11;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CAP_LO,
        RK_CAP_HI,
        RK_CFG_LO,
        RK_CFG_HI,
        RK_CNT_LO,
        RK_CNT_HI,
        RK_CHAN
    } reg_kind_e;

    typedef struct packed {
        logic run;
        logic legacy;
        logic arm;
        logic halt;
    } cfg_state_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } rsp_state_t;

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
    import evt_timer_pkg::*;
#(
    parameter int AW       = 10,
    parameter int NUM_CHAN = 3,
    localparam int OFFW    = $clog2(CHAN_STRIDE),
    localparam int IDXW    = AW - OFFW
) (
    input  logic            valid,
    input  logic            write,
    input  logic [1:0]      size,
    input  logic [AW-1:0]   addr,
    output reg_kind_e       kind,
    output logic            sel,
    output logic            we,
    output logic [IDXW-1:0] idx,
    output logic [OFFW-1:0] off
);

    localparam int WAW = AW - 2;
    localparam logic [WAW-1:0] W_CAP_LO = WAW'(OFF_CAP_LO >> 2);
    localparam logic [WAW-1:0] W_CAP_HI = WAW'(OFF_CAP_HI >> 2);
    localparam logic [WAW-1:0] W_CFG_LO = WAW'(OFF_CFG_LO >> 2);
    localparam logic [WAW-1:0] W_CFG_HI = WAW'(OFF_CFG_HI >> 2);
    localparam logic [WAW-1:0] W_CNT_LO = WAW'(OFF_CNT_LO >> 2);
    localparam logic [WAW-1:0] W_CNT_HI = WAW'(OFF_CNT_HI >> 2);
    localparam logic [AW-1:0]  A_CHAN   = AW'(CHAN_BASE);
    localparam logic [IDXW:0]  N_CHAN   = (IDXW+1)'(NUM_CHAN);

    logic            full;
    logic            in_chan;
    logic [AW-1:0]   rel;
    logic [WAW-1:0]  waddr;

    always_comb begin
        full    = valid && (size == 2'(SIZE_DWORD));
        waddr   = addr[AW-1:2];
        rel     = addr - A_CHAN;
        idx     = rel[AW-1:OFFW];
        off     = addr[OFFW-1:0];
        in_chan = (addr >= A_CHAN) && ({1'b0, idx} < N_CHAN);
        kind    = RK_NONE;
        if (full) begin
            if (addr >= A_CHAN) begin
                kind = in_chan ? RK_CHAN : RK_NONE;
            end else begin
                unique case (waddr)
                    W_CAP_LO: kind = RK_CAP_LO;
                    W_CAP_HI: kind = RK_CAP_HI;
                    W_CFG_LO: kind = RK_CFG_LO;
                    W_CFG_HI: kind = RK_CFG_HI;
                    W_CNT_LO: kind = RK_CNT_LO;
                    W_CNT_HI: kind = RK_CNT_HI;
                    default:  kind = RK_NONE;
                endcase
            end
        end
        sel = (kind == RK_CHAN);
        we  = sel && write;
    end

endmodule

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
    import evt_timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [CFG_BITS-1:0] wbits,
    output cfg_state_t          state
);

    cfg_state_t cfg_d, cfg_q;
    logic [CFG_BITS-1:0] cur, nxt;

    always_comb begin
        cur   = {cfg_q.legacy, cfg_q.run};
        nxt   = wr ? ((wbits & CFG_WMASK) | (cur & ~CFG_WMASK)) : cur;
        cfg_d        = cfg_q;
        cfg_d.run    = nxt[0];
        cfg_d.legacy = nxt[1];
        cfg_d.arm    = !cfg_q.run && nxt[0];
        cfg_d.halt   = cfg_q.run && !nxt[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign state = cfg_q;

    // R8
    arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.arm |-> (cfg_q.run && !$past(cfg_q.run)));
    // R8
    halt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.halt |-> (!cfg_q.run && $past(cfg_q.run)));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_q.arm, cfg_q.halt}));

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (run) begin
            if (tick_en) count_d = count_q + CNT_W'(1);
        end else if (wr_lo) begin
            count_d = {count_q[CNT_W-1:WORD_W], wdata};
        end else if (wr_hi) begin
            count_d = {wdata, count_q[WORD_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en) |=> (count_q == $past(count_q) + 64'd1));
    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(count_q));
    // R7
    cnt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_en) |=> $stable(count_q));

endmodule

// File: rtl/evt_timer_globals.sv
module evt_timer_globals
    import evt_timer_pkg::*;
#(
    parameter int          AW            = 10,
    parameter int          NUM_CHAN      = 3,
    parameter logic [31:0] CAP_ID        = 32'h8086A201,
    parameter logic [31:0] CLK_PERIOD_FS = 32'd10_000_000,
    localparam int         OFFW          = $clog2(CHAN_STRIDE),
    localparam int         IDXW          = AW - OFFW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [1:0]      req_size,
    input  logic [AW-1:0]   req_addr,
    input  logic [31:0]     req_wdata,
    output logic            rsp_valid,
    output logic [31:0]     rsp_rdata,
    output logic            timer_on,
    output logic            legacy_mode,
    output logic            arm_all,
    output logic            halt_all,
    output logic [63:0]     main_count,
    output logic            chan_sel,
    output logic            chan_we,
    output logic [IDXW-1:0] chan_idx,
    output logic [OFFW-1:0] chan_off,
    input  logic [31:0]     chan_rdata
);

    reg_kind_e   kind;
    cfg_state_t  cfg;
    logic [CNT_W-1:0] count;
    logic        wr_cfg, wr_cnt_lo, wr_cnt_hi, do_write;
    logic [WORD_W-1:0] rd_word;
    rsp_state_t  rsp_d, rsp_q;

    evt_addr_decode #(.AW(AW), .NUM_CHAN(NUM_CHAN)) u_dec (
        .valid (req_valid),
        .write (req_write),
        .size  (req_size),
        .addr  (req_addr),
        .kind  (kind),
        .sel   (chan_sel),
        .we    (chan_we),
        .idx   (chan_idx),
        .off   (chan_off)
    );

    always_comb begin
        do_write  = req_valid && req_write;
        wr_cfg    = do_write && (kind == RK_CFG_LO);
        wr_cnt_lo = do_write && (kind == RK_CNT_LO);
        wr_cnt_hi = do_write && (kind == RK_CNT_HI);
    end

    evt_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_cfg),
        .wbits (req_wdata[CFG_BITS-1:0]),
        .state (cfg)
    );

    evt_main_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg.run),
        .tick_en (tick_en),
        .wr_lo   (wr_cnt_lo),
        .wr_hi   (wr_cnt_hi),
        .wdata   (req_wdata),
        .count   (count)
    );

    always_comb begin
        unique case (kind)
            RK_CAP_LO: rd_word = CAP_ID;
            RK_CAP_HI: rd_word = CLK_PERIOD_FS;
            RK_CFG_LO: rd_word = {{(WORD_W-CFG_BITS){1'b0}}, cfg.legacy, cfg.run};
            RK_CNT_LO: rd_word = count[WORD_W-1:0];
            RK_CNT_HI: rd_word = count[CNT_W-1:WORD_W];
            RK_CHAN:   rd_word = chan_rdata;
            default:   rd_word = '0;
        endcase
        rsp_d.valid = req_valid && !req_write;
        rsp_d.data  = rsp_d.valid ? rd_word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_rdata   = rsp_q.data;
    assign timer_on    = cfg.run;
    assign legacy_mode = cfg.legacy;
    assign arm_all     = cfg.arm;
    assign halt_all    = cfg.halt;
    assign main_count  = count;

    // R12
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    // R12
    rsp_only_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));
    // R2
    narrow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size != 2'b10) |=> $stable({timer_on, legacy_mode}));

endmodule

// File: tb/evt_timer_globals_test.sv
module evt_timer_globals_test;

    localparam logic [31:0] CAP = 32'h8086A201;
    localparam logic [31:0] PER = 32'd10_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, timer_on, legacy_mode, arm_all, halt_all;
    logic [31:0] rsp_rdata, chan_rdata;
    logic [63:0] main_count;
    logic        chan_sel, chan_we;
    logic [4:0]  chan_idx, chan_off;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    logic [63:0] m_cnt = '0;
    logic        m_run = 0, m_leg = 0, m_arm = 0, m_halt = 0;

    always #5 clk = ~clk;

    assign chan_rdata = {16'hC4A0, 6'b0, req_addr};

    evt_timer_globals uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .timer_on(timer_on), .legacy_mode(legacy_mode),
        .arm_all(arm_all), .halt_all(halt_all), .main_count(main_count),
        .chan_sel(chan_sel), .chan_we(chan_we), .chan_idx(chan_idx),
        .chan_off(chan_off), .chan_rdata(chan_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit exp_chan(input logic [1:0] sz, input logic [9:0] a);
        return (sz == 2'b10) && (a >= 10'h100) && (((a - 10'h100) >> 5) < 3);
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [9:0] a);
        if (sz != 2'b10) return 32'h0;
        if (exp_chan(sz, a)) return {16'hC4A0, 6'b0, a};
        case (a[9:2])
            8'h00: return CAP;
            8'h01: return PER;
            8'h04: return {30'b0, m_leg, m_run};
            8'h3C: return m_cnt[31:0];
            8'h3D: return m_cnt[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] sz, input logic [9:0] a);
        if (sz != 2'b10) return "R2";
        if (exp_chan(sz, a)) return "R10";
        case (a[9:2])
            8'h00, 8'h01: return "R3";
            8'h04, 8'h05: return "R4";
            8'h3C, 8'h3D: return "R6";
            default: return "R11";
        endcase
    endfunction

    // one access cycle; called at a negedge, returns at the next negedge
    task automatic op(input logic v, input logic w, input logic [1:0] sz,
                      input logic [9:0] a, input logic [31:0] d, input logic tk);
        logic [31:0] erd;
        bit          esel;
        logic        old_run;
        req_valid = v; req_write = w; req_size = sz; req_addr = a; req_wdata = d; tick_en = tk;
        esel = v && exp_chan(sz, a);
        erd  = exp_read(sz, a);
        #1;
        chk("R10 chan_sel", chan_sel, esel);
        chk("R10 chan_we", chan_we, esel && w);
        if (esel) begin
            chk("R10 chan_idx", chan_idx, 64'((a - 10'h100) >> 5));
            chk("R10 chan_off", chan_off, 64'(a[4:0]));
        end
        old_run = m_run;
        if (v && w && sz == 2'b10) begin
            if (a[9:2] == 8'h04) begin m_run = d[0]; m_leg = d[1]; end
            if (!old_run && a[9:2] == 8'h3C) m_cnt[31:0]  = d;
            if (!old_run && a[9:2] == 8'h3D) m_cnt[63:32] = d;
        end
        if (old_run && tk) m_cnt = m_cnt + 64'd1;
        m_arm  = !old_run && m_run;
        m_halt = old_run && !m_run;
        @(posedge clk);
        #1;
        if (v && !w) begin
            chk("R12 rsp_valid", rsp_valid, 1'b1);
            chk({tag_of(sz, a), " read"}, rsp_rdata, erd);
        end else begin
            chk("R12 no response", rsp_valid, 1'b0);
        end
        chk("R5 count", main_count, m_cnt);
        chk("R9 timer_on", timer_on, m_run);
        chk("R9 legacy_mode", legacy_mode, m_leg);
        chk("R8 arm", arm_all, m_arm);
        chk("R8 halt", halt_all, m_halt);
        @(negedge clk);
    endtask

    task automatic rd(input logic [9:0] a);
        op(1, 0, 2'b10, a, 32'h0, 0);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        op(1, 1, 2'b10, a, d, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [9:0] addrs [8];
        void'($urandom(32'd1913));
        addrs[0] = 10'h000; addrs[1] = 10'h004; addrs[2] = 10'h010; addrs[3] = 10'h014;
        addrs[4] = 10'h0F0; addrs[5] = 10'h0F4; addrs[6] = 10'h100; addrs[7] = 10'h3FC;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 count", main_count, 64'h0);
        chk("R1 timer_on", timer_on, 1'b0);
        chk("R1 legacy", legacy_mode, 1'b0);
        chk("R1 arm/halt", {arm_all, halt_all}, 2'b00);
        chk("R1 rsp", {rsp_valid, rsp_rdata}, 33'h0);

        // R3 capability, read-only
        rd(10'h000); rd(10'h004);
        wr(10'h000, 32'h12345678); rd(10'h000);
        // R4 config bits, high dword
        wr(10'h010, 32'hFFFF_FFFE); rd(10'h010);
        wr(10'h014, 32'hFFFF_FFFF); rd(10'h014);
        wr(10'h010, 32'h0);
        // R2 narrow accesses
        op(1, 1, 2'b01, 10'h010, 32'h3, 0);
        op(1, 1, 2'b00, 10'h0F0, 32'hAB, 0);
        op(1, 0, 2'b00, 10'h000, 32'h0, 0);
        op(1, 0, 2'b01, 10'h004, 32'h0, 0);
        // R7 load halves while stopped, R6 carry
        wr(10'h0F0, 32'hFFFF_FFFE);
        wr(10'h0F4, 32'h0000_0007);
        rd(10'h0F0); rd(10'h0F4);
        wr(10'h010, 32'h1);
        repeat (3) op(0, 0, 2'b10, 10'h0, 32'h0, 1);
        rd(10'h0F4);
        // R7 writes ignored while running
        wr(10'h0F0, 32'h0); wr(10'h0F4, 32'h0);
        // R5 hold when tick low
        repeat (2) op(0, 0, 2'b10, 10'h0, 32'h0, 0);
        wr(10'h010, 32'h2);
        rd(10'h0F0);
        // R10, R11 channel decode and out-of-range slots
        rd(10'h100); rd(10'h15C); wr(10'h144, 32'h55);
        rd(10'h160); wr(10'h3E0, 32'h1); rd(10'h080); rd(10'h3FF);

        for (int i = 0; i < 4000; i++) begin
            logic [9:0]  a;
            logic [1:0]  sz;
            int          pick;
            pick = $urandom_range(0, 9);
            a    = (pick < 8) ? addrs[pick] : 10'($urandom_range(0, 1023) & 10'h3FC);
            sz   = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 1)) : 2'b10;
            op($urandom_range(0, 4) != 0, $urandom_range(0, 9) < 4, sz, a,
               (a == 10'h0F4) ? {28'h0, 4'($urandom)} : $urandom, $urandom_range(0, 9) < 7);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule